// File: doc/BRIEF.md
# Write-Once Configurable Watchdog Timer

This block is a watchdog counter whose behaviour is set by an 8-bit mode byte. Software may load that byte exactly once after reset. The byte picks one of two count-enable sources, or turns the watchdog off, and picks one of eight overflow lengths. The block runs on a single system clock. It receives one tick-enable strobe from a slow internal oscillator and one from the fast system clock, and advances only on the strobe that the mode byte selects. When the count reaches the chosen length, the block pulses a reset request and starts again from zero. Software keeps the system alive by pulsing a restart strobe before that happens.

The block also watches for misuse and for a dead clock source. Any write after the first one raises the reset request. If the selected strobe is absent for a configurable number of system cycles, its next arrival raises the reset request. A static strap input can lock the source to the slow oscillator. In that case any source or shutdown request in the written byte is ignored. When the strap does not lock the source, software may switch the watchdog off, and it then stays off until the next reset.

Top module: `wdog_once_top`

## Requirements
- R1: While and after reset, `rd_data` reads 0x67 and `rst_req` is low. Until a write arrives, the count runs on the slow strobe with period code 7, so a reset request falls due after 2^(SLOW_EXP0+7) slow ticks.
- R2: `rd_data` always returns {3'b011, source field, period field}. Bits 7:5 read 011 whatever was written, bits 4:3 hold the source field, and bits 2:0 hold the period code as written.
- R3: Source field (bits 4:3 of the written byte): 00 counts `tick_slow`, 01 counts `tick_fast`, and 10 or 11 stops the watchdog.
- R4: Period code c (bits 2:0) gives an overflow after 2^(SLOW_EXP0+c) selected ticks on the slow source, or 2^(FAST_EXP0+c) on the fast source. `rst_req` is then high for one cycle, in the cycle after the clock edge that took the overflowing tick, and counting restarts from zero.
- R5: The first write after reset is accepted, restarts the count from zero and raises no request. Every later write leaves the mode byte unchanged and raises `rst_req` in the following cycle.
- R6: With `strap_locked` high, the source is always `tick_slow` and the stored source field reads 00, whatever bits 4:3 carried. Bits 7:5 of the written byte have no effect.
- R7: With `strap_locked` low, an accepted write whose bit 4 is set stops the watchdog until the next reset. After that, ticks, restart strobes and later writes raise no request, and the mode byte does not change.
- R8: A `kick` pulse sets the count to zero without touching the mode byte. A tick in the same cycle does not count.
- R9: If the selected strobe has been low for at least STALL_CYCLES consecutive cycles, its next tick raises `rst_req` in the following cycle and restarts the count from zero. A gap of STALL_CYCLES-1 cycles has no effect. STALL_CYCLES=0 disables this check.
- R10: The strobe that is not selected has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_slow | input | 1 | Count enable from the slow internal oscillator |
| tick_fast | input | 1 | Count enable from the fast system clock |
| strap_locked | input | 1 | High: the slow oscillator cannot be stopped, so the source is fixed to it |
| wr_en | input | 1 | Mode byte write strobe |
| wr_data | input | 8 | Mode byte write value |
| kick | input | 1 | Restart strobe, sets the count to zero |
| rd_data | output | 8 | Current mode byte |
| rst_req | output | 1 | Internal reset request pulse |

## Verification
Every result of this block passes through one register. A tick, write or stall recovery presented in cycle t shows its effect on `rst_req` in cycle t+1, and an accepted write appears on `rd_data` in cycle t+1 as well. The bench therefore changes inputs on the falling edge and samples the outputs on the next falling edge. A period check counts falling edges from the first held tick until the pulse appears and expects exactly 2^n. During the random phase, a reference model in the bench advances by one step per sampled cycle, so its expected pulse lines up with the register stage.

// File: rtl/wdog_once_pkg.sv
package wdog_once_pkg;

   // count source encoding held in bits 4:3 of the mode byte
   typedef enum logic [1:0] {
      SRC_SLOW  = 2'b00,
      SRC_FAST  = 2'b01,
      SRC_OFF_A = 2'b10,
      SRC_OFF_B = 2'b11
   } src_sel_e;

   // mode byte layout: fixed bits, source, period code
   typedef struct packed {
      logic [2:0] fixed;
      logic [1:0] src;
      logic [2:0] per;
   } mode_t;

   localparam logic [2:0] FIXED_TOP = 3'b011;
   localparam int unsigned PER_W    = 3;
   localparam int unsigned MODE_W   = 8;

endpackage

// File: rtl/wdog_mode_reg.sv
module wdog_mode_reg
   import wdog_once_pkg::*;
#(
   parameter logic [MODE_W-1:0] RESET_MODE = 8'h67
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] wr_data,
   input  logic              strap_locked,
   output mode_t             mode_q,
   output logic              written_q,
   output logic              halt_q,
   output logic              accept,
   output logic              dup_wr
);

   mode_t wr_mode;
   logic  unused_hi;

   // bits 7:5 of a written byte never reach the register
   assign unused_hi = ^wr_data[7:5];

   always_comb begin
      wr_mode.fixed = FIXED_TOP;
      wr_mode.src   = strap_locked ? SRC_SLOW : wr_data[4:3];
      wr_mode.per   = wr_data[2:0];
   end

   assign accept = wr_en & ~written_q;
   assign dup_wr = wr_en & written_q & ~halt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= mode_t'(RESET_MODE);
         written_q <= 1'b0;
         halt_q    <= 1'b0;
      end else if (accept) begin
         mode_q    <= wr_mode;
         written_q <= 1'b1;
         halt_q    <= ~strap_locked & wr_data[4];
      end
   end

endmodule

// File: rtl/wdog_src_sel.sv
module wdog_src_sel
   import wdog_once_pkg::*;
(
   input  logic       tick_slow,
   input  logic       tick_fast,
   input  logic       strap_locked,
   input  logic       halted,
   input  logic [1:0] src,
   output logic       sel_tick,
   output logic       use_fast
);

   always_comb begin
      use_fast = ~strap_locked & (src == SRC_FAST);
      sel_tick = ~halted & (use_fast ? tick_fast : tick_slow);
   end

endmodule

// File: rtl/wdog_period_cnt.sv
module wdog_period_cnt
   import wdog_once_pkg::*;
#(
   parameter int unsigned SLOW_EXP0    = 11,
   parameter int unsigned FAST_EXP0    = 13,
   parameter int unsigned STALL_CYCLES = 1024
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             use_fast,
   input  logic             clear,
   input  logic             restart,
   input  logic             halted,
   input  logic [PER_W-1:0] per,
   output logic             ovf_evt,
   output logic             resume_evt
);

   localparam int unsigned BASE_MAX = (SLOW_EXP0 > FAST_EXP0) ? SLOW_EXP0 : FAST_EXP0;
   localparam int unsigned CNT_W    = BASE_MAX + (1 << PER_W) - 1;
   localparam int unsigned EXP_W    = $clog2(CNT_W + 1);
   localparam logic [EXP_W-1:0] SLOW_B = EXP_W'(SLOW_EXP0);
   localparam logic [EXP_W-1:0] FAST_B = EXP_W'(FAST_EXP0);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;
   logic [CNT_W:0]   span;
   logic [EXP_W-1:0] exp_sel;
   logic             stalled;

   // terminal count = 2^(base + code) - 1
   always_comb begin
      exp_sel = (use_fast ? FAST_B : SLOW_B) + EXP_W'(per);
      span    = (CNT_W + 1)'(1) << exp_sel;
      last    = CNT_W'(span - 1'b1);
   end

   // dead-source monitor, present only when a stall limit is given
   if (STALL_CYCLES > 0) begin : g_stall
      localparam int unsigned GAP_W = $clog2(STALL_CYCLES + 1);
      localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(STALL_CYCLES);
      logic [GAP_W-1:0] gap_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            gap_q <= '0;
         end else if (restart || halted || tick) begin
            gap_q <= '0;
         end else if (gap_q != GAP_MAX) begin
            gap_q <= gap_q + 1'b1;
         end
      end

      assign stalled = (gap_q == GAP_MAX);
   end else begin : g_nostall
      assign stalled = 1'b0;
   end

   assign resume_evt = tick & stalled & ~restart;
   assign ovf_evt    = tick & ~clear & ~resume_evt & (cnt_q == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear || resume_evt) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/wdog_once_top.sv
module wdog_once_top
   import wdog_once_pkg::*;
#(
   parameter int unsigned       SLOW_EXP0    = 11,
   parameter int unsigned       FAST_EXP0    = 13,
   parameter int unsigned       STALL_CYCLES = 1024,
   parameter logic [MODE_W-1:0] RESET_MODE   = 8'h67
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_slow,
   input  logic              tick_fast,
   input  logic              strap_locked,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] wr_data,
   input  logic              kick,
   output logic [MODE_W-1:0] rd_data,
   output logic              rst_req
);

   // elaboration-time parameter checks
   if (RESET_MODE[7:5] != FIXED_TOP) begin : g_bad_fixed
      $error("RESET_MODE bits 7:5 must be 011");
   end
   if (RESET_MODE[4] != 1'b0) begin : g_bad_src
      $error("RESET_MODE must not start in the stopped state");
   end
   if (SLOW_EXP0 < 1 || FAST_EXP0 < 1) begin : g_bad_exp
      $error("period base exponents must be at least 1");
   end
   if (((SLOW_EXP0 > FAST_EXP0) ? SLOW_EXP0 : FAST_EXP0) + (1 << PER_W) > 32) begin : g_bad_wide
      $error("longest period exceeds 31 counter bits");
   end

   mode_t mode_q;
   logic  written_q;
   logic  halt_q;
   logic  accept;
   logic  dup_wr;
   logic  sel_tick;
   logic  use_fast;
   logic  ovf_evt;
   logic  resume_evt;
   logic  cnt_clear;
   logic  rst_req_q;

   wdog_mode_reg #(
      .RESET_MODE (RESET_MODE)
   ) u_mode (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_data      (wr_data),
      .strap_locked (strap_locked),
      .mode_q       (mode_q),
      .written_q    (written_q),
      .halt_q       (halt_q),
      .accept       (accept),
      .dup_wr       (dup_wr)
   );

   wdog_src_sel u_src (
      .tick_slow    (tick_slow),
      .tick_fast    (tick_fast),
      .strap_locked (strap_locked),
      .halted       (halt_q),
      .src          (mode_q.src),
      .sel_tick     (sel_tick),
      .use_fast     (use_fast)
   );

   assign cnt_clear = kick | accept;

   wdog_period_cnt #(
      .SLOW_EXP0    (SLOW_EXP0),
      .FAST_EXP0    (FAST_EXP0),
      .STALL_CYCLES (STALL_CYCLES)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (sel_tick),
      .use_fast   (use_fast),
      .clear      (cnt_clear),
      .restart    (accept),
      .halted     (halt_q),
      .per        (mode_q.per),
      .ovf_evt    (ovf_evt),
      .resume_evt (resume_evt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req_q <= 1'b0;
      end else begin
         rst_req_q <= ovf_evt | resume_evt | dup_wr;
      end
   end

   assign rst_req = rst_req_q;
   assign rd_data = mode_q;

endmodule

// File: rtl/wdog_once_chk.sv
module wdog_once_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [7:0] rd_data,
   input logic       rst_req,
   input logic       written,
   input logic       halted,
   input logic       sel_tick
);

   // R7
   halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> !rst_req);

   // R5
   dup_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (written && !halted && wr_en) |=> rst_req);

   // R5
   first_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!written && wr_en) |=> (written && !rst_req));

   // R5
   frozen_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      written |=> $stable(rd_data));

   // R2
   fixed_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[7:5] == 3'b011);

   // R4
   req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> $past(sel_tick || wr_en));

endmodule

bind wdog_once_top wdog_once_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .rd_data  (rd_data),
   .rst_req  (rst_req),
   .written  (written_q),
   .halted   (halt_q),
   .sel_tick (sel_tick)
);

// File: tb/sim_wdog_once_top.sv
`timescale 1ns/1ps
module sim_wdog_once_top;

   localparam int SLOW0 = 2;
   localparam int FAST0 = 4;
   localparam int STALL = 16;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       tick_slow;
   logic       tick_fast;
   logic       strap_locked;
   logic       wr_en;
   logic [7:0] wr_data;
   logic       kick;
   logic [7:0] rd_data;
   logic       rst_req;

   int compared   = 0;
   int mismatched = 0;
   bit finished   = 1'b0;

   always #10 clk = ~clk;

   wdog_once_top #(
      .SLOW_EXP0    (SLOW0),
      .FAST_EXP0    (FAST0),
      .STALL_CYCLES (STALL)
   ) u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_slow    (tick_slow),
      .tick_fast    (tick_fast),
      .strap_locked (strap_locked),
      .wr_en        (wr_en),
      .wr_data      (wr_data),
      .kick         (kick),
      .rd_data      (rd_data),
      .rst_req      (rst_req)
   );

   function automatic int period_of(bit fast, int code);
      return 1 << ((fast ? FAST0 : SLOW0) + code);
   endfunction

   function automatic logic [7:0] read_of(bit locked, logic [7:0] w);
      return {3'b011, (locked ? 2'b00 : w[4:3]), w[2:0]};
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic reset_dut(input bit locked);
      @(negedge clk);
      rst_n = 1'b0; tick_slow = 1'b0; tick_fast = 1'b0;
      wr_en = 1'b0; wr_data = 8'h00; kick = 1'b0; strap_locked = locked;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic write_mode(input logic [7:0] v);
      wr_en = 1'b1; wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // hold the selected tick high, count cycles until the request shows
   task automatic measure(input bit fast_sel, output int n);
      n = 0;
      while (n < 5000) begin
         if (fast_sel) begin tick_fast = 1'b1; tick_slow = 1'($urandom % 2); end
         else          begin tick_slow = 1'b1; tick_fast = 1'($urandom % 2); end
         @(negedge clk);
         n++;
         if (rst_req) break;
      end
      tick_slow = 1'b0; tick_fast = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         compared++; mismatched++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      int n;
      int hits;
      void'($urandom(32'd20917));
      rst_n = 1'b0; tick_slow = 1'b0; tick_fast = 1'b0; strap_locked = 1'b0;
      wr_en = 1'b0; wr_data = 8'h00; kick = 1'b0;

      // R1 reset state and default period
      reset_dut(1'b0);
      chk("R1 reset read", int'(rd_data), 32'h67);
      chk("R1 reset req", int'(rst_req), 0);
      measure(1'b0, n);
      chk("R1 default period", n, period_of(1'b0, 7));
      measure(1'b0, n);
      chk("R4 restart after overflow", n, period_of(1'b0, 7));

      // R4 R3 R2 R10 every code on both sources
      for (int fs = 0; fs < 2; fs++) begin
         for (int code = 0; code < 8; code++) begin
            logic [7:0] v;
            v = {3'($urandom), 1'b0, 1'(fs), 3'(code)};
            reset_dut(1'b0);
            write_mode(v);
            chk("R5 first write no req", int'(rst_req), 0);
            chk("R2 readback", int'(rd_data), int'(read_of(1'b0, v)));
            measure(1'(fs), n);
            chk(fs ? "R3 R4 R10 fast period" : "R4 R10 slow period", n, period_of(1'(fs), code));
         end
      end

      // R5 second and third write
      reset_dut(1'b0);
      write_mode(8'h01);
      tick_slow = 1'b1;
      repeat (3) @(negedge clk);
      chk("R5 before second write", int'(rst_req), 0);
      write_mode(8'h0F);
      chk("R5 second write req", int'(rst_req), 1);
      chk("R5 mode kept", int'(rd_data), 32'h61);
      @(negedge clk);
      chk("R4 R5 single cycle pulse", int'(rst_req), 0);
      write_mode(8'h13);
      chk("R5 third write req", int'(rst_req), 1);
      chk("R5 mode kept again", int'(rd_data), 32'h61);
      tick_slow = 1'b0;

      // R6 locked source
      reset_dut(1'b1);
      write_mode(8'h0A);
      chk("R6 locked readback", int'(rd_data), 32'h62);
      measure(1'b0, n);
      chk("R6 locked period on slow", n, period_of(1'b0, 2));
      reset_dut(1'b1);
      write_mode(8'hF2);
      chk("R6 stop ignored readback", int'(rd_data), 32'h62);
      measure(1'b0, n);
      chk("R6 stop ignored period", n, period_of(1'b0, 2));

      // R7 permanent stop
      reset_dut(1'b0);
      write_mode(8'h13);
      chk("R7 stop readback", int'(rd_data), 32'h73);
      hits = 0;
      for (int i = 0; i < 3000; i++) begin
         bit idle;
         idle = (i >= 1000 && i < 1040);
         tick_slow = idle ? 1'b0 : 1'($urandom % 2);
         tick_fast = idle ? 1'b0 : 1'($urandom % 2);
         kick = ($urandom % 20 == 0);
         @(negedge clk);
         if (rst_req) hits++;
      end
      tick_slow = 1'b0; tick_fast = 1'b0; kick = 1'b0;
      chk("R7 no req while stopped", hits, 0);
      write_mode(8'h00);
      chk("R7 later write no req", int'(rst_req), 0);
      chk("R7 mode kept", int'(rd_data), 32'h73);

      // R3 code 11 also stops
      reset_dut(1'b0);
      write_mode(8'h18);
      chk("R3 off code readback", int'(rd_data), 32'h78);
      hits = 0;
      tick_slow = 1'b1; tick_fast = 1'b1;
      repeat (1100) begin
         @(negedge clk);
         if (rst_req) hits++;
      end
      tick_slow = 1'b0; tick_fast = 1'b0;
      chk("R3 off code no req", hits, 0);

      // R8 kick
      reset_dut(1'b0);
      write_mode(8'h00);
      tick_slow = 1'b1;
      repeat (3) @(negedge clk);
      chk("R8 before kick", int'(rst_req), 0);
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
      chk("R8 kick beats tick", int'(rst_req), 0);
      chk("R8 mode untouched", int'(rd_data), 32'h60);
      measure(1'b0, n);
      chk("R8 full period after kick", n, period_of(1'b0, 0));

      // R9 stall recovery
      reset_dut(1'b0);
      write_mode(8'h01);
      tick_slow = 1'b1;
      repeat (2) @(negedge clk);
      tick_slow = 1'b0;
      hits = 0;
      repeat (STALL - 1) begin
         @(negedge clk);
         if (rst_req) hits++;
      end
      chk("R9 idle no req", hits, 0);
      tick_slow = 1'b1;
      @(negedge clk);
      chk("R9 gap below limit", int'(rst_req), 0);
      tick_slow = 1'b0;
      repeat (STALL) @(negedge clk);
      tick_slow = 1'b1;
      @(negedge clk);
      chk("R9 resume req", int'(rst_req), 1);
      measure(1'b0, n);
      chk("R9 restart after resume", n, period_of(1'b0, 1));

      // random phase against a bench reference model (R4 R8 R9 R10)
      begin
         bit   fs;
         int   code, per, cnt_m, gap_m, burst;
         bit   tk, kk, res, ovf;
         fs = 1'($urandom % 2);
         code = $urandom % 4;
         per = period_of(fs, code);
         reset_dut(1'b0);
         write_mode({3'b011, 1'b0, fs, 3'(code)});
         cnt_m = 0; gap_m = 0; burst = 0;
         for (int i = 0; i < 4000; i++) begin
            if (burst > 0) begin
               burst--; tk = 1'b0;
            end else if ($urandom % 50 == 0) begin
               burst = 10 + $urandom % 12; tk = 1'b0;
            end else begin
               tk = ($urandom % 10 < 6);
            end
            kk = ($urandom % 30 == 0);
            if (fs) begin tick_fast = tk; tick_slow = 1'($urandom % 2); end
            else    begin tick_slow = tk; tick_fast = 1'($urandom % 2); end
            kick = kk;
            @(negedge clk);
            res = tk && (gap_m == STALL);
            ovf = tk && !kk && !res && (cnt_m == per - 1);
            chk("R4 R8 R9 R10 random", int'(rst_req), int'(ovf || res));
            if (kk || res) cnt_m = 0;
            else if (tk) cnt_m = (cnt_m == per - 1) ? 0 : cnt_m + 1;
            if (tk) gap_m = 0;
            else if (gap_m < STALL) gap_m++;
         end
         tick_slow = 1'b0; tick_fast = 1'b0; kick = 1'b0;
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule